// File: doc/BRIEF.md
# Configurable Serial Frame Deserializer

This block takes a 16-bit serial frame and pulls out a 14-bit data word. The frame arrives on three lines: a data line, a serial clock and an active-low frame-sync. A faster system clock oversamples all three lines. Each one first passes through a synchronizer. The block then looks for falling edges on the serial clock and on the sync line.

A falling edge on sync opens a frame. The next sixteen falling edges of the serial clock each sample one data bit. Fourteen of these bits form the word and two are padding. Two layout inputs decide where the word sits in the frame:

- **Bit order:** least significant bit first, or most significant bit first.
- **Padding position:** the two padding bits at the head of the frame, or at the tail.

The block captures the layout inputs when the frame opens.

After the sixteenth bit, the block presents the assembled word together with a one-cycle valid strobe for the downstream holding register. If sync is released before all sixteen bits have arrived, the frame is dropped and no strobe is given.

Top module: `serframe_rx`

## Requirements
- R1: While reset is asserted, `word_out` is all zeros and `word_vld` is low.
- R2: With `cfg_msb_first`=0 and `cfg_pad_tail`=0, frame bits 1 and 2 are discarded, bit 3 becomes `word_out[0]` and bit 16 becomes `word_out[13]` (bits numbered from 1 in arrival order).
- R3: With `cfg_msb_first`=0 and `cfg_pad_tail`=1, bit 1 becomes `word_out[0]`, bit 14 becomes `word_out[13]`, and bits 15 and 16 are discarded.
- R4: With `cfg_msb_first`=1 and `cfg_pad_tail`=0, bits 1 and 2 are discarded, bit 3 becomes `word_out[13]` and bit 16 becomes `word_out[0]`.
- R5: With `cfg_msb_first`=1 and `cfg_pad_tail`=1, bit 1 becomes `word_out[13]`, bit 14 becomes `word_out[0]`, and bits 15 and 16 are discarded.
- R6: A bit is taken only on a falling edge of `ser_clk` that occurs while `ser_fs_n` is low after its falling edge. `word_vld` is high for exactly one `clk` cycle. It rises at the third rising `clk` edge that samples the sixteenth low level of `ser_clk` (two synchronizer stages plus one output register).
- R7: If `ser_fs_n` returns high before the sixteenth bit, the frame is discarded: no `word_vld` pulse is issued and `word_out` keeps its previous value.
- R8: The layout inputs are captured in the cycle the sync falling edge is detected. Changes to them during the rest of the frame have no effect on that frame's word.
- R9: After the sixteenth bit, further serial clock falling edges are ignored until `ser_fs_n` goes high and falls again. No second pulse follows from one sync assertion.
- R10: `word_out` changes only in a cycle where `word_vld` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data line |
| ser_fs_n | input | 1 | Active-low frame sync; its falling edge opens a frame |
| cfg_msb_first | input | 1 | Layout select: 1 = most significant bit arrives first |
| cfg_pad_tail | input | 1 | Layout select: 1 = padding bits at the end of the frame |
| word_out | output | 14 | Last completed data word |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
The assertions assume that each serial clock level lasts at least two system clock cycles, so that every falling edge survives synchronization as one detected edge. They also assume that data is steady across the falling edge it belongs to, and that a sync edge never lands in the same cycle as a serial clock falling edge. The stimulus holds each serial clock half-period for three system cycles. It changes data only while the serial clock is high. It keeps four idle cycles between any sync edge and the nearest serial clock edge. The layout inputs change either well before a frame opens or deliberately in the middle of one.

// File: rtl/serframe_pkg.sv
package serframe_pkg;

   // Frame layout selection, captured once per frame.
   typedef struct packed {
      logic msb_first;   // 1: most significant data bit arrives first
      logic pad_tail;    // 1: padding bits sit after the data bits
   } layout_t;

   localparam int unsigned FRAME_BITS_DEF  = 16;
   localparam int unsigned DATA_BITS_DEF   = 14;
   localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/serframe_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
module serframe_sync #(
   parameter int unsigned     WIDTH   = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/serframe_edge.sv
// Falling-edge detection on the synchronized serial clock and frame sync.
module serframe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic fs_n_s,
   output logic sclk_fall,
   output logic fs_fall
);

   logic sclk_d;
   logic fs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         fs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         fs_d   <= fs_n_s;
      end
   end

   assign sclk_fall = sclk_d & ~sclk_s;
   assign fs_fall   = fs_d & ~fs_n_s;

endmodule

// File: rtl/serframe_shift.sv
// Frame tracking: bit counter, shift register and per-frame layout capture.
module serframe_shift
   import serframe_pkg::*;
#(
   parameter int unsigned FRAME_BITS = FRAME_BITS_DEF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fs_n_s,
   input  logic                  fs_fall,
   input  logic                  sclk_fall,
   input  logic                  sdata_s,
   input  layout_t               layout_in,
   output logic                  frm_active,
   output layout_t               layout_q,
   output logic                  frame_done,
   output logic [FRAME_BITS-1:0] frame_bits
);

   localparam int unsigned      CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] sr;
   logic [CNT_W-1:0]      cnt;
   logic                  take;

   // A bit is taken only inside an open frame with sync still low.
   assign take       = frm_active & ~fs_n_s & ~fs_fall & sclk_fall;
   // Earliest bit ends up in the top position after a full frame.
   assign frame_bits = {sr[FRAME_BITS-2:0], sdata_s};
   assign frame_done = take & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_active <= 1'b0;
         cnt        <= '0;
         sr         <= '0;
         layout_q   <= '0;
      end else if (fs_n_s) begin
         frm_active <= 1'b0;
      end else if (fs_fall) begin
         frm_active <= 1'b1;
         cnt        <= '0;
         layout_q   <= layout_in;
      end else if (take) begin
         sr  <= frame_bits;
         cnt <= cnt + CNT_W'(1);
         if (cnt == LAST) begin
            frm_active <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/serframe_map.sv
// Selects the data window inside the frame and applies the bit order.
module serframe_map
   import serframe_pkg::*;
#(
   parameter int unsigned FRAME_BITS = FRAME_BITS_DEF,
   parameter int unsigned DATA_BITS  = DATA_BITS_DEF
) (
   input  logic [FRAME_BITS-1:0] frame,
   input  layout_t               layout,
   output logic [DATA_BITS-1:0]  word
);

   localparam int unsigned PAD = FRAME_BITS - DATA_BITS;

   logic [DATA_BITS-1:0] win_head;
   logic [DATA_BITS-1:0] win_tail;
   logic [DATA_BITS-1:0] win;
   logic [DATA_BITS-1:0] rev;

   // Padding at the start: data occupies the latest bits.
   assign win_head = frame[DATA_BITS-1:0];
   // Padding at the end: data occupies the earliest bits.
   assign win_tail = frame[FRAME_BITS-1:PAD];
   assign win      = layout.pad_tail ? win_tail : win_head;

   generate
      for (genvar i = 0; i < DATA_BITS; i++) begin : g_rev
         assign rev[i] = win[DATA_BITS-1-i];
      end
   endgenerate

   // The earliest data bit sits at the window top, which is the MSB in
   // MSB-first order and must be mirrored to bit 0 in LSB-first order.
   assign word = layout.msb_first ? win : rev;

endmodule

// File: rtl/serframe_rx.sv
// Top level: synchronize, detect edges, assemble frame, register the word.
module serframe_rx
   import serframe_pkg::*;
#(
   parameter int unsigned FRAME_BITS  = FRAME_BITS_DEF,
   parameter int unsigned DATA_BITS   = DATA_BITS_DEF,
   parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_data,
   input  logic                 ser_fs_n,
   input  logic                 cfg_msb_first,
   input  logic                 cfg_pad_tail,
   output logic [DATA_BITS-1:0] word_out,
   output logic                 word_vld
);

   generate
      if (DATA_BITS >= FRAME_BITS) begin : g_bad_widths
         $error("serframe_rx: DATA_BITS must be smaller than FRAME_BITS");
      end
      if (DATA_BITS < 2) begin : g_bad_data
         $error("serframe_rx: DATA_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serframe_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                  fs_n_s;
   logic                  sclk_s;
   logic                  sdata_s;
   logic                  sclk_fall;
   logic                  fs_fall;
   logic                  frm_active;
   logic                  frame_done;
   logic [FRAME_BITS-1:0] frame_bits;
   logic [DATA_BITS-1:0]  mapped;
   layout_t               layout_in;
   layout_t               layout_q;
   logic [DATA_BITS-1:0]  word_q;
   logic                  vld_q;

   assign layout_in.msb_first = cfg_msb_first;
   assign layout_in.pad_tail  = cfg_pad_tail;

   serframe_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_fs_n, ser_clk, ser_data}),
      .q     ({fs_n_s, sclk_s, sdata_s})
   );

   serframe_edge edge_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .fs_n_s    (fs_n_s),
      .sclk_fall (sclk_fall),
      .fs_fall   (fs_fall)
   );

   serframe_shift #(
      .FRAME_BITS (FRAME_BITS)
   ) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fs_n_s     (fs_n_s),
      .fs_fall    (fs_fall),
      .sclk_fall  (sclk_fall),
      .sdata_s    (sdata_s),
      .layout_in  (layout_in),
      .frm_active (frm_active),
      .layout_q   (layout_q),
      .frame_done (frame_done),
      .frame_bits (frame_bits)
   );

   serframe_map #(
      .FRAME_BITS (FRAME_BITS),
      .DATA_BITS  (DATA_BITS)
   ) map_i (
      .frame  (frame_bits),
      .layout (layout_q),
      .word   (mapped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= frame_done;
         if (frame_done) begin
            word_q <= mapped;
         end
      end
   end

   assign word_out = word_q;
   assign word_vld = vld_q;

endmodule

// File: rtl/serframe_rx_chk.sv
// Property checker bound to serframe_rx.
module serframe_rx_chk
   import serframe_pkg::*;
#(
   parameter int unsigned DATA_BITS = DATA_BITS_DEF
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 word_vld,
   input logic [DATA_BITS-1:0] word_out,
   input logic                 fs_n_s,
   input logic                 frm_active,
   input layout_t              layout_q
);

   // R6
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out));

   // R7
   vld_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(!fs_n_s));

   // R9
   vld_closes_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> !frm_active);

   // R8
   layout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_active && $past(frm_active)) |-> $stable(layout_q));

endmodule

bind serframe_rx serframe_rx_chk #(
   .DATA_BITS (DATA_BITS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_vld   (word_vld),
   .word_out   (word_out),
   .fs_n_s     (fs_n_s),
   .frm_active (frm_active),
   .layout_q   (layout_q)
);

// File: tb/serframe_rx_tb.sv
module serframe_rx_tb_top;

   localparam int DB = 14;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          rst_n = 1'b0;
   logic          ser_clk = 1'b1;
   logic          ser_data = 1'b0;
   logic          ser_fs_n = 1'b1;
   logic          cfg_msb_first = 1'b0;
   logic          cfg_pad_tail = 1'b0;
   logic [DB-1:0] word_out;
   logic          word_vld;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   int    pulses = 0;
   int    run_len = 0;
   int    max_run = 0;
   bit    finished = 1'b0;
   string phase = "R1";
   logic [DB-1:0] last_word = '0;

   serframe_rx dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ser_clk       (ser_clk),
      .ser_data      (ser_data),
      .ser_fs_n      (ser_fs_n),
      .cfg_msb_first (cfg_msb_first),
      .cfg_pad_tail  (cfg_pad_tail),
      .word_out      (word_out),
      .word_vld      (word_vld)
   );

   // Expected word from the layout rules; f[k-1] holds frame bit k.
   function automatic logic [DB-1:0] expect_word(logic [23:0] f, logic msb, logic tail);
      logic [DB-1:0] w;
      for (int i = 0; i < DB; i++) begin
         case ({msb, tail})
            2'b00:   w[i] = f[2 + i];   // R2
            2'b01:   w[i] = f[i];       // R3
            2'b10:   w[i] = f[15 - i];  // R4
            default: w[i] = f[13 - i];  // R5
         endcase
      end
      return w;
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Behavioural reference model, two synchronizer cycles behind the pins.
   logic          hs [0:2];
   logic          hf [0:2];
   logic          hd [0:2];
   bit            m_active = 1'b0;
   int            m_cnt = 0;
   logic [23:0]   m_f = '0;
   logic          m_msb = 1'b0;
   logic          m_tail = 1'b0;
   logic [DB-1:0] m_word = '0;
   logic          m_vld = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            hs[i] = 1'b1;
            hf[i] = 1'b1;
            hd[i] = 1'b0;
         end
         m_active = 1'b0;
         m_cnt    = 0;
         m_word   = '0;
         m_vld    = 1'b0;
      end else begin
         m_vld = 1'b0;
         if (hf[1]) begin
            m_active = 1'b0;
         end else if (hf[2]) begin
            m_active = 1'b1;
            m_cnt    = 0;
            m_msb    = cfg_msb_first;
            m_tail   = cfg_pad_tail;
         end else if (m_active && hs[2] && !hs[1]) begin
            m_f[m_cnt] = hd[1];
            m_cnt++;
            if (m_cnt == 16) begin
               m_vld    = 1'b1;
               m_word   = expect_word(m_f, m_msb, m_tail);
               m_active = 1'b0;
            end
         end
         hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = ser_clk;
         hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = ser_fs_n;
         hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = ser_data;
      end
   end

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(word_vld === m_vld, {phase, "/R6"}, "word_vld vs model", 32'(word_vld), 32'(m_vld));
         check(word_out === m_word, {phase, "/R10"}, "word_out vs model", 32'(word_out), 32'(m_word));
         if (word_vld) begin
            pulses++;
            last_word = word_out;
            run_len++;
            if (run_len > max_run) max_run = run_len;
         end else begin
            run_len = 0;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL R6 watchdog expired: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic send_frame(logic [23:0] f, int nbits, logic msb, logic tail,
                             int chg_at, logic nmsb, logic ntail);
      @(negedge clk);
      cfg_msb_first = msb;
      cfg_pad_tail  = tail;
      repeat (4) @(negedge clk);
      ser_fs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < nbits; k++) begin
         if (k == chg_at) begin
            cfg_msb_first = nmsb;
            cfg_pad_tail  = ntail;
         end
         ser_data = f[k];
         repeat (3) @(negedge clk);
         ser_clk = 1'b0;
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
      end
      repeat (4) @(negedge clk);
      ser_fs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic run_frame(logic [23:0] f, int nbits, logic msb, logic tail,
                            int chg_at, logic nmsb, logic ntail, int exp_pulses, string req);
      int            p0;
      logic [DB-1:0] w0;
      p0    = pulses;
      w0    = word_out;
      phase = req;
      send_frame(f, nbits, msb, tail, chg_at, nmsb, ntail);
      check((pulses - p0) == exp_pulses, req, "pulse count", 32'(pulses - p0), 32'(exp_pulses));
      if (exp_pulses == 1) begin
         check(last_word === expect_word(f, msb, tail), req, "word",
               32'(last_word), 32'(expect_word(f, msb, tail)));
      end else begin
         check(word_out === w0, req, "word held", 32'(word_out), 32'(w0));
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check(word_out === '0, "R1", "word_out in reset", 32'(word_out), 32'h0);
      check(word_vld === 1'b0, "R1", "word_vld in reset", 32'(word_vld), 32'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2: LSB first, padding at start
      run_frame(24'h000004, 16, 1'b0, 1'b0, -1, 1'b0, 1'b0, 1, "R2");
      run_frame(24'h00A5C3, 16, 1'b0, 1'b0, -1, 1'b0, 1'b0, 1, "R2");
      // R3: LSB first, padding at end
      run_frame(24'h000001, 16, 1'b0, 1'b1, -1, 1'b0, 1'b0, 1, "R3");
      run_frame(24'h00C35A, 16, 1'b0, 1'b1, -1, 1'b0, 1'b0, 1, "R3");
      // R4: MSB first, padding at start
      run_frame(24'h000004, 16, 1'b1, 1'b0, -1, 1'b0, 1'b0, 1, "R4");
      run_frame(24'h003E71, 16, 1'b1, 1'b0, -1, 1'b0, 1'b0, 1, "R4");
      // R5: MSB first, padding at end
      run_frame(24'h000001, 16, 1'b1, 1'b1, -1, 1'b0, 1'b0, 1, "R5");
      run_frame(24'h009B2D, 16, 1'b1, 1'b1, -1, 1'b0, 1'b0, 1, "R5");

      // R7: sync released early, including one bit short
      run_frame(24'h00FFFF, 10, 1'b0, 1'b0, -1, 1'b0, 1'b0, 0, "R7");
      run_frame(24'h005555, 15, 1'b1, 1'b1, -1, 1'b0, 1'b0, 0, "R7");
      // Frame after an abort starts counting afresh
      run_frame(24'h001234, 16, 1'b1, 1'b0, -1, 1'b0, 1'b0, 1, "R7");

      // R8: layout changed mid-frame has no effect
      run_frame(24'h00BEEF, 16, 1'b0, 1'b0, 5, 1'b1, 1'b1, 1, "R8");
      run_frame(24'h006D19, 16, 1'b1, 1'b1, 9, 1'b0, 1'b0, 1, "R8");

      // R9: extra edges after the sixteenth bit are ignored
      run_frame(24'hFF7A3C, 20, 1'b0, 1'b1, -1, 1'b0, 1'b0, 1, "R9");

      // R6: every pulse lasted one cycle
      check(max_run == 1, "R6", "longest word_vld run", 32'(max_run), 32'd1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule